// File: doc/BRIEF.md
# Multiply-Add ALU Slice

This block is a single arithmetic and logic slice of the sort tiled into signal-processing datapaths. A signed 25x18 multiplier, the concatenation of the two multiplier operands, a third operand C, a cascade input from the slice below and the slice's own registered result all feed three operand selectors called X, Y and Z. A 7-bit operand-select word picks each selector's source, and it may change on every cycle. A 4-bit function code then either adds or subtracts the three selected operands together with a carry-in, or applies a bitwise logic function to X and Z. The result goes into a single output register. That register drives the result port and the cascade output.

A build parameter splits the 48-bit adder into one, two or four independent lanes. Carries do not pass between lanes, and each lane reports its own carry-out. A masked comparator checks the unregistered result against either a constant pattern or the C operand, and it registers its verdict in the same edge as the result. With Z set to the slice's own result, the slice works as an accumulator. With Z set to the cascade input shifted right by 17 places, slices chain into wider multipliers.

Top module: `mac_alu_slice`

## Requirements
- R1: While rst_n is low, p, pcout, carryout and pattern_hit are all zero. They clear at once, without waiting for a clock edge.
- R2: opmode[1:0] selects X. 00 gives zero, 10 gives the registered result p, and 11 gives the zero-extended concatenation {a_in, b_in}, with b_in in the low 18 bits.
- R3: opmode[3:2] selects Y. 00 and 10 give zero, and 11 gives c_in. The signed product a_in*b_in, sign-extended to 48 bits, enters the sum once, and only when both X and Y select code 01. If only one of them selects 01, that selector gives zero. Example: opmode 0110101 gives a_in*b_in + c_in.
- R4: opmode[6:4] selects Z. 000, 100 and 111 give zero. 001 gives pcin, 010 gives p and 011 gives c_in. 101 and 110 give pcin and p shifted right by 17 places, with the sign bit copied into the vacated upper bits.
- R5: alumode 0000 produces Z + X + Y + carry_in. alumode 0011 produces Z - (X + Y + carry_in).
- R6: alumode 0001 produces -Z + (X + Y + carry_in) - 1. alumode 0010 produces the bitwise inverse of Z + X + Y + carry_in.
- R7: When alumode[2] is 1 and opmode[3] is 0, the function is bitwise on X and Z. 0100 and 0111 give XOR, 0101 and 0110 give XNOR, 1100 gives AND, 1101 gives X AND NOT Z, 1110 gives NAND and 1111 gives NOT X OR Z.
- R8: When alumode[2] is 1 and opmode[3] is 1, the function is bitwise on X and Z. 0100 and 0111 give XNOR, 0101 and 0110 give XOR, 1100 gives OR, 1101 gives X OR NOT Z, 1110 gives NOR and 1111 gives NOT X AND Z.
- R9: With LANES lanes, each lane is 48/LANES bits wide and no carry or borrow crosses a lane boundary. carry_in enters lane 0 only. The carry-out of lane k appears on carryout[(k+1)*4/LANES-1], and the other bits of carryout are 0. Carry-outs are reported only for alumode 0000. They are 0 for every other alumode.
- R10: pattern_hit is 1 when the new result equals the pattern in every bit where MASK is 0. Bits set in MASK are ignored. The pattern is the PATTERN parameter, or c_in when USE_C_PATTERN is 1.
- R11: p, carryout and pattern_hit change at the first rising clock edge after their inputs are applied. pcout always equals p.
- R12: With opmode 0100000, alumode 0000 and carry_in 0, p holds its value. With Z = p and other operands selected, p accumulates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opmode | input | 7 | Operand select: Z in [6:4], Y in [3:2], X in [1:0] |
| alumode | input | 4 | Arithmetic or logic function code |
| carry_in | input | 1 | Carry into the sum (lane 0) |
| a_in | input | 25 | Signed multiplier operand, upper part of the concatenation |
| b_in | input | 18 | Signed multiplier operand, lower part of the concatenation |
| c_in | input | 48 | Third operand, also the optional pattern |
| pcin | input | 48 | Cascade input from the slice below |
| p | output | 48 | Registered result |
| pcout | output | 48 | Cascade output, equal to p |
| carryout | output | 4 | Per-lane carry-outs, placed as in R9 |
| pattern_hit | output | 1 | Registered masked pattern match |

## Verification
Every result is due exactly one rising edge after its operands are applied: p, pcout, carryout and pattern_hit all come from the same register stage. The one exception is reset, which clears them with no edge. The bench drives every operand at a falling edge and reads the outputs at the next falling edge, half a period after the capturing edge. Vectors that use the fed-back result are placed in table order, so that the expected p of one row follows from the row before it. The lane and pattern-from-C cases run on a second four-lane instance with the same timing.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

    localparam int CO_W = 4;

    typedef enum logic [1:0] {
        XS_ZERO = 2'b00,
        XS_PROD = 2'b01,
        XS_PREG = 2'b10,
        XS_CAT  = 2'b11
    } xsel_e;

    typedef enum logic [1:0] {
        YS_ZERO = 2'b00,
        YS_PROD = 2'b01,
        YS_RSVD = 2'b10,
        YS_C    = 2'b11
    } ysel_e;

    typedef enum logic [2:0] {
        ZS_ZERO   = 3'b000,
        ZS_PCIN   = 3'b001,
        ZS_PREG   = 3'b010,
        ZS_C      = 3'b011,
        ZS_RSVD4  = 3'b100,
        ZS_PCIN_S = 3'b101,
        ZS_PREG_S = 3'b110,
        ZS_RSVD7  = 3'b111
    } zsel_e;

    localparam logic [3:0] FN_ADD    = 4'b0000;
    localparam logic [3:0] FN_NZADD  = 4'b0001;
    localparam logic [3:0] FN_NOTSUM = 4'b0010;
    localparam logic [3:0] FN_SUB    = 4'b0011;

endpackage

// File: rtl/mac_operand_mux.sv
module mac_operand_mux
    import mac_slice_pkg::*;
#(
    parameter int DW    = 48,
    parameter int AW    = 25,
    parameter int BW    = 18,
    parameter int SHIFT = 17
) (
    input  logic [6:0]    opmode,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    input  logic [DW-1:0] c_in,
    input  logic [DW-1:0] pcin,
    input  logic [DW-1:0] preg,
    output logic [DW-1:0] x_op,
    output logic [DW-1:0] y_op,
    output logic [DW-1:0] z_op
);
    localparam int PW = AW + BW;

    xsel_e xsel;
    ysel_e ysel;
    zsel_e zsel;

    logic signed [PW-1:0] prod;
    logic [DW-1:0] prod_ext;
    logic [DW-1:0] cat_ext;
    logic [DW-1:0] pcin_sh;
    logic [DW-1:0] preg_sh;
    logic          prod_ok;

    assign xsel = xsel_e'(opmode[1:0]);
    assign ysel = ysel_e'(opmode[3:2]);
    assign zsel = zsel_e'(opmode[6:4]);

    assign prod     = $signed(a_in) * $signed(b_in);
    assign prod_ext = {{(DW-PW){prod[PW-1]}}, prod};
    assign cat_ext  = {{(DW-PW){1'b0}}, a_in, b_in};
    assign pcin_sh  = DW'($signed(pcin) >>> SHIFT);
    assign preg_sh  = DW'($signed(preg) >>> SHIFT);
    assign prod_ok  = (xsel == XS_PROD) && (ysel == YS_PROD);

    always_comb begin
        unique case (xsel)
            XS_ZERO: x_op = '0;
            XS_PROD: x_op = prod_ok ? prod_ext : '0;
            XS_PREG: x_op = preg;
            XS_CAT:  x_op = cat_ext;
            default: x_op = '0;
        endcase
    end

    always_comb begin
        unique case (ysel)
            YS_C:    y_op = c_in;
            default: y_op = '0;
        endcase
    end

    always_comb begin
        unique case (zsel)
            ZS_PCIN:   z_op = pcin;
            ZS_PREG:   z_op = preg;
            ZS_C:      z_op = c_in;
            ZS_PCIN_S: z_op = pcin_sh;
            ZS_PREG_S: z_op = preg_sh;
            default:   z_op = '0;
        endcase
    end

endmodule

// File: rtl/mac_lane_alu.sv
module mac_lane_alu
    import mac_slice_pkg::*;
#(
    parameter int DW    = 48,
    parameter int LANES = 1
) (
    input  logic [DW-1:0]   x_op,
    input  logic [DW-1:0]   y_op,
    input  logic [DW-1:0]   z_op,
    input  logic            carry_in,
    input  logic [3:0]      alumode,
    input  logic            y_hi,
    output logic [DW-1:0]   result,
    output logic [CO_W-1:0] carry_vec
);
    localparam int LW      = DW / LANES;
    localparam int CO_STEP = CO_W / LANES;

    logic            inv_z;
    logic            inv_out;
    logic            is_add;
    logic [DW-1:0]   arith_res;
    logic [DW-1:0]   logic_res;
    logic [LANES-1:0] lane_co;

    assign inv_z   = (alumode == FN_SUB) || (alumode == FN_NZADD);
    assign inv_out = (alumode == FN_SUB) || (alumode == FN_NOTSUM);
    assign is_add  = (alumode == FN_ADD);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] zl;
        logic [LW+1:0] sum;
        logic          lane_cin;

        assign lane_cin = (g == 0) ? carry_in : 1'b0;
        assign zl  = inv_z ? ~z_op[g*LW +: LW] : z_op[g*LW +: LW];
        assign sum = {2'b00, zl} + {2'b00, x_op[g*LW +: LW]}
                   + {2'b00, y_op[g*LW +: LW]} + {{(LW+1){1'b0}}, lane_cin};
        assign arith_res[g*LW +: LW] = inv_out ? ~sum[LW-1:0] : sum[LW-1:0];
        assign lane_co[g] = sum[LW];
    end

    always_comb begin
        carry_vec = '0;
        for (int k = 0; k < LANES; k++) begin
            carry_vec[(k+1)*CO_STEP-1] = lane_co[k] & is_add;
        end
    end

    always_comb begin
        if (!y_hi) begin
            case (alumode)
                4'b0100, 4'b0111: logic_res = x_op ^ z_op;
                4'b0101, 4'b0110: logic_res = ~(x_op ^ z_op);
                4'b1100:          logic_res = x_op & z_op;
                4'b1101:          logic_res = x_op & ~z_op;
                4'b1110:          logic_res = ~(x_op & z_op);
                4'b1111:          logic_res = ~x_op | z_op;
                default:          logic_res = '0;
            endcase
        end else begin
            case (alumode)
                4'b0100, 4'b0111: logic_res = ~(x_op ^ z_op);
                4'b0101, 4'b0110: logic_res = x_op ^ z_op;
                4'b1100:          logic_res = x_op | z_op;
                4'b1101:          logic_res = x_op | ~z_op;
                4'b1110:          logic_res = ~(x_op | z_op);
                4'b1111:          logic_res = ~x_op & z_op;
                default:          logic_res = '0;
            endcase
        end
    end

    always_comb begin
        if (alumode[2])                result = logic_res;
        else if (alumode[3:2] == 2'b00) result = arith_res;
        else                           result = '0;
    end

endmodule

// File: rtl/mac_pattern_match.sv
module mac_pattern_match #(
    parameter int          DW            = 48,
    parameter bit          USE_C_PATTERN = 1'b0,
    parameter logic [47:0] PATTERN       = 48'h0,
    parameter logic [47:0] MASK          = 48'h0
) (
    input  logic [DW-1:0] result,
    input  logic [DW-1:0] c_in,
    output logic          hit
);
    logic [DW-1:0] pat;
    logic [DW-1:0] care;

    if (USE_C_PATTERN) begin : g_pat_c
        assign pat = c_in;
    end else begin : g_pat_k
        assign pat = DW'(PATTERN);
    end

    assign care = ~DW'(MASK);
    assign hit  = ((result ^ pat) & care) == '0;

endmodule

// File: rtl/mac_alu_slice.sv
module mac_alu_slice
    import mac_slice_pkg::*;
#(
    parameter int          DW            = 48,
    parameter int          AW            = 25,
    parameter int          BW            = 18,
    parameter int          LANES         = 1,
    parameter int          SHIFT         = 17,
    parameter bit          USE_C_PATTERN = 1'b0,
    parameter logic [47:0] PATTERN       = 48'h0,
    parameter logic [47:0] MASK          = 48'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [6:0]      opmode,
    input  logic [3:0]      alumode,
    input  logic            carry_in,
    input  logic [AW-1:0]   a_in,
    input  logic [BW-1:0]   b_in,
    input  logic [DW-1:0]   c_in,
    input  logic [DW-1:0]   pcin,
    output logic [DW-1:0]   p,
    output logic [DW-1:0]   pcout,
    output logic [CO_W-1:0] carryout,
    output logic            pattern_hit
);
    logic [DW-1:0]   x_op;
    logic [DW-1:0]   y_op;
    logic [DW-1:0]   z_op;
    logic [DW-1:0]   res_d;
    logic [CO_W-1:0] co_d;
    logic            hit_d;

    logic [DW-1:0]   p_q;
    logic [CO_W-1:0] co_q;
    logic            hit_q;

    mac_operand_mux #(
        .DW(DW), .AW(AW), .BW(BW), .SHIFT(SHIFT)
    ) u_mux (
        .opmode (opmode),
        .a_in   (a_in),
        .b_in   (b_in),
        .c_in   (c_in),
        .pcin   (pcin),
        .preg   (p_q),
        .x_op   (x_op),
        .y_op   (y_op),
        .z_op   (z_op)
    );

    mac_lane_alu #(
        .DW(DW), .LANES(LANES)
    ) u_alu (
        .x_op      (x_op),
        .y_op      (y_op),
        .z_op      (z_op),
        .carry_in  (carry_in),
        .alumode   (alumode),
        .y_hi      (opmode[3]),
        .result    (res_d),
        .carry_vec (co_d)
    );

    mac_pattern_match #(
        .DW(DW), .USE_C_PATTERN(USE_C_PATTERN), .PATTERN(PATTERN), .MASK(MASK)
    ) u_pat (
        .result (res_d),
        .c_in   (c_in),
        .hit    (hit_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q   <= '0;
            co_q  <= '0;
            hit_q <= 1'b0;
        end else begin
            p_q   <= res_d;
            co_q  <= co_d;
            hit_q <= hit_d;
        end
    end

    assign p           = p_q;
    assign pcout       = p_q;
    assign carryout    = co_q;
    assign pattern_hit = hit_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (p == '0 && carryout == '0 && !pattern_hit));

    // R9
    logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alumode[2] |=> carryout == '0);

    // R12
    hold_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opmode == 7'b0100000 && alumode == 4'b0000 && !carry_in) |=> $stable(p));

    // R7
    xor_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opmode == 7'b0100010 && alumode == 4'b0100) |=> p == '0);

    // R3
    lone_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opmode == 7'b0000001 && alumode == 4'b0000 && !carry_in) |=> p == '0);

endmodule

// File: tb/mac_alu_slice_tb_top.sv
module mac_alu_slice_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 24;

    typedef struct packed {
        logic [6:0]  op;
        logic [3:0]  alu;
        logic        cin;
        logic [24:0] a;
        logic [17:0] b;
        logic [47:0] c;
        logic [47:0] pc;
        logic [47:0] exp_p;
        logic [3:0]  exp_co;
        logic        exp_hit;
        logic [7:0]  req;
    } vec_t;

    // Rows run in order; rows that read p depend on the row before.
    localparam vec_t TBL [NVEC] = '{
        '{7'b0110101, 4'b0000, 1'b0, 25'd3, 18'h3FFFB, 48'd100, 48'h0, 48'h55, 4'b1000, 1'b0, 8'd3},          // R3 a*b+c
        '{7'b0110011, 4'b0000, 1'b0, 25'd1, 18'd2, 48'h10, 48'h0, 48'h40012, 4'b0000, 1'b0, 8'd2},             // R2 c+{a,b}
        '{7'b0011110, 4'b0000, 1'b0, 25'd0, 18'd0, 48'h100, 48'h1000, 48'h41112, 4'b0000, 1'b0, 8'd12},        // R12 p+c+pcin
        '{7'b1010000, 4'b0000, 1'b0, 25'd0, 18'd0, 48'h0, 48'h800000000000, 48'hFFFFC0000000, 4'b0000, 1'b0, 8'd4}, // R4 pcin>>>17
        '{7'b1100000, 4'b0000, 1'b0, 25'd0, 18'd0, 48'h0, 48'h0, 48'hFFFFFFFFE000, 4'b0000, 1'b0, 8'd4},       // R4 p>>>17
        '{7'b0110011, 4'b0011, 1'b0, 25'd0, 18'h100, 48'h500, 48'h0, 48'h400, 4'b0000, 1'b0, 8'd5},            // R5 subtract
        '{7'b0110011, 4'b0000, 1'b1, 25'd0, 18'd0, 48'hFFFFFFFFFFFF, 48'h0, 48'h0, 4'b1000, 1'b1, 8'd5},       // R5 carry-in, wrap
        '{7'b0110011, 4'b0001, 1'b0, 25'd0, 18'd10, 48'd5, 48'h0, 48'd4, 4'b0000, 1'b0, 8'd6},                 // R6 -z+x-1
        '{7'b0110011, 4'b0010, 1'b1, 25'd0, 18'd10, 48'd5, 48'h0, 48'hFFFFFFFFFFEF, 4'b0000, 1'b0, 8'd6},      // R6 inverted sum
        '{7'b0110011, 4'b0100, 1'b0, 25'd0, 18'h0FF0, 48'hF0F0, 48'h0, 48'hFF00, 4'b0000, 1'b0, 8'd7},         // R7 xor
        '{7'b0110011, 4'b1100, 1'b0, 25'd0, 18'h0FF0, 48'hF0F0, 48'h0, 48'h00F0, 4'b0000, 1'b0, 8'd7},         // R7 and
        '{7'b0110011, 4'b1110, 1'b0, 25'd0, 18'h0FF0, 48'hF0F0, 48'h0, 48'hFFFFFFFFFF0F, 4'b0000, 1'b0, 8'd7}, // R7 nand
        '{7'b0111011, 4'b1100, 1'b0, 25'd0, 18'h0FF0, 48'hF0F0, 48'h0, 48'hFFF0, 4'b0000, 1'b0, 8'd8},         // R8 or
        '{7'b0111011, 4'b1110, 1'b0, 25'd0, 18'h0FF0, 48'hF0F0, 48'h0, 48'hFFFFFFFF000F, 4'b0000, 1'b0, 8'd8}, // R8 nor
        '{7'b0111011, 4'b0100, 1'b0, 25'd0, 18'h0FF0, 48'hF0F0, 48'h0, 48'hFFFFFFFF00FF, 4'b0000, 1'b0, 8'd8}, // R8 xnor
        '{7'b0110011, 4'b0101, 1'b0, 25'd0, 18'h0FF0, 48'hF0F0, 48'h0, 48'hFFFFFFFF00FF, 4'b0000, 1'b0, 8'd7}, // R7 xnor
        '{7'b0000010, 4'b0000, 1'b0, 25'd0, 18'd0, 48'h0, 48'h0, 48'hFFFFFFFF00FF, 4'b0000, 1'b0, 8'd2},       // R2 x=p
        '{7'b0000001, 4'b0000, 1'b0, 25'd3, 18'd3, 48'h0, 48'h0, 48'h0, 4'b0000, 1'b1, 8'd3},                  // R3 lone product
        '{7'b0001100, 4'b0000, 1'b0, 25'd0, 18'd0, 48'h1234, 48'h0, 48'h1234, 4'b0000, 1'b0, 8'd3},            // R3 y=c
        '{7'b0100000, 4'b0000, 1'b0, 25'd0, 18'd0, 48'h0, 48'h0, 48'h1234, 4'b0000, 1'b0, 8'd12},              // R12 hold
        '{7'b0010000, 4'b0000, 1'b0, 25'd0, 18'd0, 48'h0, 48'hABCDE, 48'hABCDE, 4'b0000, 1'b0, 8'd4},          // R4 z=pcin
        '{7'b1000000, 4'b0000, 1'b0, 25'd0, 18'd0, 48'h0, 48'hABCDE, 48'h0, 4'b0000, 1'b1, 8'd4},              // R4 code 100
        '{7'b0000101, 4'b0000, 1'b0, 25'h1FFFFFE, 18'h3FFFD, 48'h0, 48'h0, 48'd6, 4'b0000, 1'b0, 8'd3},        // R3 neg*neg
        '{7'b0000101, 4'b0000, 1'b0, 25'h1000000, 18'h20000, 48'h0, 48'h0, 48'h020000000000, 4'b0000, 1'b0, 8'd3} // R3 extremes
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  opmode = '0;
    logic [3:0]  alumode = '0;
    logic        carry_in = 1'b0;
    logic [24:0] a_in = '0;
    logic [17:0] b_in = '0;
    logic [47:0] c_in = '0;
    logic [47:0] pcin = '0;
    logic [47:0] p, pcout, p4, pcout4;
    logic [3:0]  carryout, carryout4;
    logic        pattern_hit, pattern_hit4;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_alu_slice dut_i (
        .clk(clk), .rst_n(rst_n), .opmode(opmode), .alumode(alumode),
        .carry_in(carry_in), .a_in(a_in), .b_in(b_in), .c_in(c_in), .pcin(pcin),
        .p(p), .pcout(pcout), .carryout(carryout), .pattern_hit(pattern_hit)
    );

    mac_alu_slice #(
        .LANES(4), .USE_C_PATTERN(1'b1), .MASK(48'h00000000FFFF)
    ) dut4_i (
        .clk(clk), .rst_n(rst_n), .opmode(opmode), .alumode(alumode),
        .carry_in(carry_in), .a_in(a_in), .b_in(b_in), .c_in(c_in), .pcin(pcin),
        .p(p4), .pcout(pcout4), .carryout(carryout4), .pattern_hit(pattern_hit4)
    );

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] op, input logic [3:0] alu, input logic ci,
                         input logic [24:0] a, input logic [17:0] b,
                         input logic [47:0] c, input logic [47:0] pc);
        opmode = op; alumode = alu; carry_in = ci;
        a_in = a; b_in = b; c_in = c; pcin = pc;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, before any edge with rst_n high
        chk("R1 p in reset", p, 48'h0);
        chk("R1 carryout in reset", {44'h0, carryout}, 48'h0);
        chk("R1 hit in reset", {47'h0, pattern_hit}, 48'h0);
        chk("R1 p4 in reset", p4, 48'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].op, TBL[i].alu, TBL[i].cin, TBL[i].a, TBL[i].b, TBL[i].c, TBL[i].pc);
            @(negedge clk);
            // R11: due one edge later
            chk($sformatf("R%0d row %0d p", TBL[i].req, i), p, TBL[i].exp_p);
            chk($sformatf("R9 row %0d carryout", i), {44'h0, carryout}, {44'h0, TBL[i].exp_co});
            chk($sformatf("R10 row %0d hit", i), {47'h0, pattern_hit}, {47'h0, TBL[i].exp_hit});
            chk($sformatf("R11 row %0d pcout", i), pcout, p);
        end

        // R9: four lanes, add with carries out of lanes 0 only
        drive(7'b0110011, 4'b0000, 1'b0, 25'd0, 18'd1, 48'h001FFF800FFF, 48'h0);
        @(negedge clk);
        chk("R9 lane add p", p4, 48'h001FFF800000);
        chk("R9 lane add carryout", {44'h0, carryout4}, 48'h1);
        chk("R10 masked c pattern hit", {47'h0, pattern_hit4}, 48'h1);

        // R9: every lane carries, none propagates
        drive(7'b0111100, 4'b0000, 1'b0, 25'd0, 18'd0, 48'h800800800800, 48'h0);
        @(negedge clk);
        chk("R9 all lanes carry p", p4, 48'h0);
        chk("R9 all lanes carryout", {44'h0, carryout4}, 48'hF);
        chk("R10 c pattern miss", {47'h0, pattern_hit4}, 48'h0);

        // R9: borrow stays in lane 0
        drive(7'b0110011, 4'b0011, 1'b0, 25'd0, 18'd1, 48'h0, 48'h0);
        @(negedge clk);
        chk("R9 lane borrow p", p4, 48'h000000000FFF);
        chk("R9 subtract carryout zero", {44'h0, carryout4}, 48'h0);
        chk("R10 masked low bits ignored", {47'h0, pattern_hit4}, 48'h1);

        // R9: carry-in only into lane 0
        drive(7'b0110011, 4'b0000, 1'b1, 25'd0, 18'd0, 48'h000000000FFF, 48'h0);
        @(negedge clk);
        chk("R9 lane carry-in p", p4, 48'h0);
        chk("R9 lane carry-in carryout", {44'h0, carryout4}, 48'h1);

        // R1: asynchronous reset mid-run
        drive(7'b0110011, 4'b0000, 1'b0, 25'd0, 18'd7, 48'h0, 48'h0);
        @(negedge clk);
        chk("R2 before reset", p, 48'h7);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear p", p, 48'h0);
        chk("R1 async clear pcout", pcout, 48'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 first result after reset", p, 48'h7);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule